// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block runs from the oscillator clock of an 8051-style controller and times the strobes of its external memory bus. It divides the oscillator into machine cycles of twelve clocks (six states of two phases each). At the end of each machine cycle it takes the next bus request from the CPU: a code fetch, an idle cycle, an external data read or an external data write. For a code fetch it decides from the external-access pin and the program counter whether the byte comes from on-chip memory. It then drives the address-latch strobe, the program-store strobe and the data read and write strobes through the coming machine cycle.

The block also filters the raw reset pin. A reset only takes effect once the pin has been high for two whole machine cycles, and shorter pulses are ignored. The CPU watches `cyc_last` and holds `req_kind`, `pc` and `ea` steady while it is high. The request is taken at the clock edge that ends that phase. No data passes through the block, so it has no handshake and no back-pressure. Every port is a plain control or status pin, and the CPU must have a request ready in every machine cycle. The reset pin must be low for at least one clock after power-up so that the qualifier starts from a known count.

Top module: `sbus_strobe_seq`

## Requirements
- R1: On a code fetch or an idle cycle, `ale` is high for two clocks in phases 0-1 and again in phases 6-7 of the machine cycle. This gives one pulse every six oscillator clocks.
- R2: On a data cycle (`req_kind` 2'b10 read or 2'b11 write), `ale` is high in phases 0-1 only, and the pulse in phases 6-7 is dropped.
- R3: On a code fetch (`req_kind` 2'b00) that maps off-chip, `psen_n` is low in phases 2-4 and 8-10. Each of these windows starts right after an `ale` falling edge.
- R4: On a data cycle, `psen_n` stays high for the whole cycle. `rd_n` (read) or `wr_n` (write) is low in phases 6-10 instead.
- R5: On a code fetch that maps on-chip, and on an idle cycle (`req_kind` 2'b01), `psen_n` stays high for the whole machine cycle.
- R6: `fetch_int` is high for the whole machine cycle when the request was taken with `ea` high and `pc` at or below 16'h0FFF. With `ea` low, every fetch is off-chip.
- R7: `rd_n` and `wr_n` are never low together.
- R8: `rst_active` rises only after `rst_pin` has been sampled high on 24 consecutive clocks, which is two machine cycles. A shorter high pulse has no effect. `rst_active` falls on the first clock at which the pin is sampled low.
- R9: While `rst_active` is high, `ale` and `fetch_int` are low, `psen_n`, `rd_n`, `wr_n` and `cyc_last` are high, and the cycle counter is held at its last phase. The first clock edge after release starts phase 0.
- R10: `cyc_last` is high exactly in phase 11. The request inputs are taken at the clock edge that ends that phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_pin | input | 1 | Raw reset pin, active high, qualified internally |
| req_kind | input | 2 | Next request: 00 code fetch, 01 idle, 10 data read, 11 data write |
| pc | input | 16 | Fetch address for the next machine cycle |
| ea | input | 1 | External-access select; high permits on-chip fetches |
| cyc_last | output | 1 | High in the last phase of the machine cycle, when the request is taken |
| ale | output | 1 | Address-latch strobe, active high |
| psen_n | output | 1 | Program-store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| fetch_int | output | 1 | Current cycle's fetch address maps on-chip |
| rst_active | output | 1 | Qualified reset in force |

## Verification
The bound checker watches, on every clock, that the read and write strobes never overlap and that the program strobe stays quiet whenever the mapping flag is high. It also checks that each address-latch pulse lasts exactly two clocks and that every program-strobe window opens right after an address-latch pulse. It further checks that the mapping flag follows the inputs taken at the cycle boundary, that all strobes are inactive one clock into a qualified reset, and that reset never rises before 24 consecutive high samples. Some behaviour only the bench scenarios can show: the exact phase of every pulse for each request kind, the dropped address-latch pulse on data cycles, the 0FFF boundary on both sides, a 20-clock reset pulse being ignored, and the counter restarting at phase 0 after a release.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef enum logic [1:0] {
    REQ_CODE = 2'b00,
    REQ_IDLE = 2'b01,
    REQ_DRD  = 2'b10,
    REQ_DWR  = 2'b11
  } req_e;

  typedef struct packed {
    logic ale;
    logic psen_n;
    logic rd_n;
    logic wr_n;
  } strobe_t;

  localparam strobe_t STROBE_OFF = '{ale: 1'b0, psen_n: 1'b1, rd_n: 1'b1, wr_n: 1'b1};
endpackage

// File: rtl/sbus_rst_qual.sv
module sbus_rst_qual #(
  parameter int HOLD_CLKS = 24
) (
  input  logic clk,
  input  logic rst_pin,
  output logic rst_active
);
  localparam int CW = $clog2(HOLD_CLKS + 1);
  localparam logic [CW-1:0] HOLD = CW'(HOLD_CLKS);

  logic [CW-1:0] hi_cnt;

  // saturating count of consecutive high samples; a low sample clears it
  always_ff @(posedge clk) begin
    if (!rst_pin)           hi_cnt <= '0;
    else if (hi_cnt != HOLD) hi_cnt <= hi_cnt + 1'b1;
  end

  assign rst_active = (hi_cnt == HOLD);
endmodule

// File: rtl/sbus_phase_ctr.sv
module sbus_phase_ctr #(
  parameter int MC_CLKS = 12,
  localparam int PW = $clog2(MC_CLKS)
) (
  input  logic          clk,
  input  logic          hold,
  output logic [PW-1:0] phase,
  output logic [PW-1:0] phase_nxt,
  output logic          last
);
  localparam logic [PW-1:0] LAST = PW'(MC_CLKS - 1);

  assign last      = (phase == LAST);
  assign phase_nxt = last ? '0 : phase + 1'b1;

  // parked at the last phase during reset so the first free edge opens phase 0
  always_ff @(posedge clk) begin
    if (hold) phase <= LAST;
    else      phase <= phase_nxt;
  end
endmodule

// File: rtl/sbus_strobe_dec.sv
module sbus_strobe_dec
  import sbus_pkg::*;
#(
  parameter int CLK_PER_STATE = 2,
  parameter int HALF          = 6,
  parameter int PSEN_LEN      = 3,
  parameter int PW            = 4
) (
  input  logic [PW-1:0] phase,
  input  req_e          kind,
  input  logic          fetch_int,
  output strobe_t       strobe
);
  localparam logic [PW-1:0] HALF_P  = PW'(HALF);
  localparam logic [PW-1:0] ALE_END = PW'(CLK_PER_STATE);
  localparam logic [PW-1:0] WIN_END = PW'(CLK_PER_STATE + PSEN_LEN);

  logic          second;
  logic [PW-1:0] offset;
  logic          in_ale, in_psen, in_xfer, is_data;

  always_comb begin
    second  = (phase >= HALF_P);
    offset  = second ? phase - HALF_P : phase;
    in_ale  = (offset < ALE_END);
    in_psen = (offset >= ALE_END) && (offset < WIN_END);
    in_xfer = second && (offset < WIN_END);
    is_data = (kind == REQ_DRD) || (kind == REQ_DWR);

    strobe.ale    = in_ale && !(second && is_data);
    strobe.psen_n = !((kind == REQ_CODE) && !fetch_int && in_psen);
    strobe.rd_n   = !((kind == REQ_DRD) && in_xfer);
    strobe.wr_n   = !((kind == REQ_DWR) && in_xfer);
  end
endmodule

// File: rtl/sbus_strobe_seq.sv
module sbus_strobe_seq
  import sbus_pkg::*;
#(
  parameter int                PC_W          = 16,
  parameter logic [PC_W-1:0]   INT_TOP       = 16'h0FFF,
  parameter int                CLK_PER_STATE = 2,
  parameter int                STATES        = 6,
  parameter int                PSEN_LEN      = 3,
  parameter int                RST_MC        = 2
) (
  input  logic            clk,
  input  logic            rst_pin,
  input  logic [1:0]      req_kind,
  input  logic [PC_W-1:0] pc,
  input  logic            ea,
  output logic            cyc_last,
  output logic            ale,
  output logic            psen_n,
  output logic            rd_n,
  output logic            wr_n,
  output logic            fetch_int,
  output logic            rst_active
);
  localparam int MC_CLKS  = STATES * CLK_PER_STATE;
  localparam int HALF     = MC_CLKS / 2;
  localparam int RST_CLKS = RST_MC * MC_CLKS;
  localparam int PW       = $clog2(MC_CLKS);

  logic [PW-1:0] phase, phase_nxt;
  logic          last;
  req_e          kind_q, kind_nxt;
  logic          fint_q, fint_nxt, map_int;
  strobe_t       strobe_q, strobe_nxt;

  sbus_rst_qual #(.HOLD_CLKS(RST_CLKS)) u_rst (
    .clk        (clk),
    .rst_pin    (rst_pin),
    .rst_active (rst_active)
  );

  sbus_phase_ctr #(.MC_CLKS(MC_CLKS)) u_ctr (
    .clk       (clk),
    .hold      (rst_active),
    .phase     (phase),
    .phase_nxt (phase_nxt),
    .last      (last)
  );

  assign map_int  = ea && (pc <= INT_TOP);
  assign kind_nxt = last ? req_e'(req_kind) : kind_q;
  assign fint_nxt = last ? map_int : fint_q;

  sbus_strobe_dec #(
    .CLK_PER_STATE (CLK_PER_STATE),
    .HALF          (HALF),
    .PSEN_LEN      (PSEN_LEN),
    .PW            (PW)
  ) u_dec (
    .phase     (phase_nxt),
    .kind      (kind_nxt),
    .fetch_int (fint_nxt),
    .strobe    (strobe_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst_active) begin
      kind_q   <= REQ_IDLE;
      fint_q   <= 1'b0;
      strobe_q <= STROBE_OFF;
    end else begin
      kind_q   <= kind_nxt;
      fint_q   <= fint_nxt;
      strobe_q <= strobe_nxt;
    end
  end

  assign cyc_last  = last;
  assign fetch_int = fint_q;
  assign ale       = strobe_q.ale;
  assign psen_n    = strobe_q.psen_n;
  assign rd_n      = strobe_q.rd_n;
  assign wr_n      = strobe_q.wr_n;
endmodule

// File: rtl/sbus_strobe_chk.sv
module sbus_strobe_chk #(
  parameter int              HOLD_CLKS = 24,
  parameter logic [15:0]     INT_TOP   = 16'h0FFF
) (
  input logic        clk,
  input logic        rst_pin,
  input logic [15:0] pc,
  input logic        ea,
  input logic        cyc_last,
  input logic        ale,
  input logic        psen_n,
  input logic        rd_n,
  input logic        wr_n,
  input logic        fetch_int,
  input logic        rst_active
);
  logic       seen_rst = 1'b0;
  logic [7:0] hi_seen  = 8'd0;
  logic       live;

  always @(posedge clk) begin
    if (rst_active === 1'b1) seen_rst <= 1'b1;
    if (!rst_pin)            hi_seen  <= 8'd0;
    else if (hi_seen != 8'hFF) hi_seen <= hi_seen + 8'd1;
  end

  assign live = seen_rst && (rst_active === 1'b0);

  p_rd_wr_excl_r7: assert property (@(posedge clk) disable iff (!live)
    !(!rd_n && !wr_n));

  p_psen_quiet_r5: assert property (@(posedge clk) disable iff (!live)
    fetch_int |-> psen_n);

  p_ale_width_r1: assert property (@(posedge clk) disable iff (!live)
    $rose(ale) |=> ale ##1 !ale);

  p_psen_after_ale_r3: assert property (@(posedge clk) disable iff (!live)
    $fell(psen_n) |-> $past(ale));

  p_map_r6: assert property (@(posedge clk) disable iff (!live)
    cyc_last |=> (fetch_int == $past(ea && (pc <= INT_TOP))));

  p_idle_in_reset_r9: assert property (@(posedge clk) disable iff (!seen_rst)
    rst_active |=> (!ale && psen_n && rd_n && wr_n));

  p_qual_hold_r8: assert property (@(posedge clk)
    $rose(rst_active) |-> (hi_seen >= 8'(HOLD_CLKS)));
endmodule

bind sbus_strobe_seq sbus_strobe_chk u_chk (.*);

// File: tb/tb_sbus_strobe_seq.sv
module tb_sbus_strobe_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_pin = 1'b0;
  logic [1:0]  req_kind = 2'b01;
  logic [15:0] pc = 16'h0000;
  logic        ea = 1'b1;
  logic        cyc_last, ale, psen_n, rd_n, wr_n, fetch_int, rst_active;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // item: kind[11:10] phase[9:6] {cyc_last,ale,psen_n,rd_n,wr_n,fetch_int}[5:0]
  typedef logic [11:0] item_t;
  item_t exp_q[$];

  sbus_strobe_seq dut (
    .clk(clk), .rst_pin(rst_pin), .req_kind(req_kind), .pc(pc), .ea(ea),
    .cyc_last(cyc_last), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .fetch_int(fetch_int), .rst_active(rst_active)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [5:0] expect_bits(logic [1:0] k, int ph, logic e, logic [15:0] a);
    logic fi, al, ps, rd, wr;
    fi = e && (a <= 16'h0FFF);                                   // R6
    al = (ph < 2) || (ph >= 6 && ph < 8 && !k[1]);               // R1, R2
    ps = !(k == 2'b00 && !fi && ((ph >= 2 && ph <= 4) || (ph >= 8 && ph <= 10))); // R3, R5
    rd = !(k == 2'b10 && ph >= 6 && ph <= 10);                   // R4
    wr = !(k == 2'b11 && ph >= 6 && ph <= 10);                   // R4
    return {(ph == 11), al, ps, rd, wr, fi};                     // R10
  endfunction

  task automatic check(string req, logic act, logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, expv, $time);
    end
  endtask

  // driver: called at a negedge in the last phase; pushes one machine cycle
  task automatic run_cycle(logic [1:0] k, logic [15:0] a, logic e);
    req_kind = k; pc = a; ea = e;
    #1;
    for (int ph = 0; ph < 12; ph++)
      exp_q.push_back({k, 4'(ph), expect_bits(k, ph, e, a)});
    repeat (12) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      item_t it;
      logic [5:0] got;
      string tag;
      it  = exp_q.pop_front();
      got = {cyc_last, ale, psen_n, rd_n, wr_n, fetch_int};
      checks++;
      if (got !== it[5:0]) begin
        errors++;
        if (got[5] !== it[5])      tag = "R10";
        else if (got[4] !== it[4]) tag = it[11] ? "R2" : "R1";
        else if (got[3] !== it[3]) tag = it[11] ? "R4" : (it[10] ? "R5" : "R3");
        else if (got[2:1] !== it[2:1]) tag = "R4";
        else                       tag = "R6";
        $display("FAIL %s: phase %0d kind %b actual %b expected %b",
                 tag, it[9:6], it[11:10], got, it[5:0]);
      end
      check("R7", !rd_n && !wr_n, 1'b0);
    end
  end

  task automatic report;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (2) @(negedge clk);

    // R8: qualification needs 24 consecutive high samples
    rst_pin = 1'b1;
    repeat (23) @(negedge clk);
    check("R8", rst_active, 1'b0);
    @(negedge clk);
    check("R8", rst_active, 1'b1);
    repeat (4) @(negedge clk);
    // R9: reset state
    check("R9", ale, 1'b0);
    check("R9", psen_n, 1'b1);
    check("R9", rd_n, 1'b1);
    check("R9", wr_n, 1'b1);
    check("R9", cyc_last, 1'b1);
    check("R9", fetch_int, 1'b0);

    rst_pin = 1'b0;
    @(negedge clk);
    check("R8", rst_active, 1'b0);
    check("R9", ale, 1'b0);

    // first free edge starts phase 0 (R9, R10)
    run_cycle(2'b00, 16'h0100, 1'b1);   // on-chip fetch, R5 R6
    run_cycle(2'b00, 16'h0FFF, 1'b1);   // boundary, still on-chip
    run_cycle(2'b00, 16'h1000, 1'b1);   // just above boundary, off-chip R3
    run_cycle(2'b00, 16'h0010, 1'b0);   // ea low forces off-chip
    run_cycle(2'b10, 16'h0020, 1'b1);   // data read R2 R4
    run_cycle(2'b11, 16'h2000, 1'b0);   // data write
    run_cycle(2'b01, 16'h3000, 1'b0);   // idle cycle R5
    run_cycle(2'b00, 16'hFFFF, 1'b1);

    // R8: a 20-clock pulse is ignored while traffic continues
    fork
      begin
        run_cycle(2'b00, 16'h4000, 1'b1);
        run_cycle(2'b11, 16'h0000, 1'b1);
        run_cycle(2'b00, 16'h0800, 1'b1);
      end
      begin
        @(negedge clk);
        rst_pin = 1'b1;
        repeat (20) @(negedge clk);
        check("R8", rst_active, 1'b0);
        rst_pin = 1'b0;
      end
    join
    check("R8", rst_active, 1'b0);

    // mid-stream reset then restart
    @(negedge clk);
    exp_q.delete();
    rst_pin = 1'b1;
    repeat (26) @(negedge clk);
    check("R8", rst_active, 1'b1);
    check("R9", ale, 1'b0);
    check("R9", psen_n, 1'b1);
    check("R9", cyc_last, 1'b1);
    rst_pin = 1'b0;
    @(negedge clk);
    run_cycle(2'b10, 16'h1234, 1'b1);
    run_cycle(2'b00, 16'h8000, 1'b1);
    repeat (2) @(negedge clk);
    report();
  end
endmodule